// File: doc/BRIEF.md
# Reset Cause and Run Control

This block merges three reset sources into one system reset. The sources are a power-on level, a watchdog expiry pulse and a USB bus-reset pulse. Every reset event starts a fixed window during which `sys_rst_o` is high. That output resets the other registers of the chip: the device address, the interrupt enables and the two stack pointers.

An 8-bit status/control register records which sources caused a reset. The cause flags are sticky and stay set until firmware clears them. The same register holds a run bit that can only be cleared, and a suspend bit that stops the oscillator. Firmware reads and writes the register through a plain I/O port (address, write strobe, write data and combinational read data).

The block also has these outputs:
- a CPU run enable;
- a one-cycle request to fetch from the reset vector, which is held back while the part is suspended until a wake-up event arrives;
- a USB transmitter enable, which stays off while a watchdog cause is still recorded.

Top module: `rst_cause_ctl`

## Requirements
- R1: While `por_i` is high and for 3 cycles after it falls, `sys_rst_o` is high. The register then reads 0x11: run (bit 0) and power-on cause (bit 4) are set, and every other bit is 0.
- R2: Each watchdog or USB event keeps `sys_rst_o` high for exactly 4 cycles after the event edge. An event inside that window restarts the 4-cycle count, so overlapping events form one reset.
- R3: A watchdog event sets bit 6 and a USB reset event sets bit 5. When both occur in one merged reset, both bits are set. Neither event changes bit 4.
- R4: A write clears each of bits 4, 5 and 6 where its data bit is 0, and never sets them. A power-on reset sets bit 4 and clears bits 5 and 6.
- R5: Bits 1, 2 and 7 always read 0, whatever value was written to them.
- R6: A write with bit 0 = 0 clears the run bit. A write with bit 0 = 1 does not set it again. Only a watchdog, USB or power-on reset sets it.
- R7: `usb_tx_en_o` is low during `sys_rst_o` and whenever bit 6 is set. It rises in the cycle after firmware writes bit 6 to 0.
- R8: `vec_fetch_o` pulses high for one cycle, in the first cycle after `sys_rst_o` falls, when suspend is clear.
- R9: A write sets or clears suspend (bit 3), and `clk_stop_o` follows it. Resets other than power-on leave suspend unchanged. While suspend is set, the vector fetch is held. A `wake_i` pulse clears suspend and releases the held fetch in the following cycle. A wake with suspend clear has no effect.
- R10: `cpu_run_o` is high only when the run bit is set, `sys_rst_o` is low and suspend is clear.
- R11: The register answers only at I/O address 0xFF. Reads at any other address return 0, and writes at any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset level, active high, sampled on the clock |
| wdt_evt_i | input | 1 | Watchdog expiry, one-cycle pulse |
| usb_rst_evt_i | input | 1 | USB bus reset detected, one-cycle pulse |
| wake_i | input | 1 | Wake-up event, one-cycle pulse |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, combinational |
| sys_rst_o | output | 1 | System reset to the other registers |
| cpu_run_o | output | 1 | CPU run enable |
| vec_fetch_o | output | 1 | Request to fetch from the reset vector |
| usb_tx_en_o | output | 1 | USB transmitter enable |
| clk_stop_o | output | 1 | Suspend: stop the oscillator and the interval timers |

## Verification
A flag that is cleared wrongly, or left set, is visible at the read port in the first cycle after the offending edge. A wrong watchdog flag also shows at once on `usb_tx_en_o`. A reset-window counter that is off by one changes the length of the `sys_rst_o` pulse and moves the `vec_fetch_o` pulse by a cycle. The bench therefore counts both across merged and single events. A suspend state that is not held shows up as a vector fetch during suspend, or as a missing fetch after the wake-up.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_SUSP = 3;
  localparam int unsigned B_POR  = 4;
  localparam int unsigned B_USB  = 5;
  localparam int unsigned B_WDT  = 6;

  localparam logic [7:0] M_SUSP      = 8'h08;
  localparam logic [7:0] M_CLR_ONLY  = 8'h71;  // run and the three cause flags
  localparam logic [7:0] M_RSVD      = 8'h86;
  localparam logic [7:0] POWERON_VAL = 8'h11;

  // Next register value after a write and any reset events in one cycle
  function automatic logic [7:0] scr_update(
    input logic [7:0] cur,
    input logic       wr,
    input logic [7:0] wd,
    input logic       wdt_evt,
    input logic       usb_evt,
    input logic       wake
  );
    logic [7:0] keep, nxt, setm;
    keep = wr ? wd : 8'hFF;
    nxt  = cur & keep & M_CLR_ONLY;
    nxt  = nxt | ((wr ? wd : cur) & M_SUSP);
    setm = 8'h00;
    setm[B_WDT] = wdt_evt;
    setm[B_USB] = usb_evt;
    setm[B_RUN] = wdt_evt | usb_evt;
    nxt  = nxt | setm;
    if (wake) nxt = nxt & ~M_SUSP;
    return nxt & ~M_RSVD;
  endfunction

  function automatic logic [7:0] read_view(input logic [7:0] scr, input logic hit);
    return hit ? (scr & ~M_RSVD) : 8'h00;
  endfunction
endpackage

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic evt_i,
  output logic rst_o,
  output logic end_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (por_i || evt_i)       cnt_q <= CNT_W'(RST_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign rst_o = por_i || (cnt_q != '0);
  assign end_o = (cnt_q == CNT_W'(1)) && !evt_i && !por_i;

  AST_RST_RELOAD: assert property (@(posedge clk) disable iff (por_i)
    evt_i |=> rst_o);                                          // R2
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (por_i)
    end_o |=> !rst_o);                                         // R2
endmodule

// File: rtl/rcc_state.sv
module rcc_state
  import rcc_pkg::*;
(
  input  logic       clk,
  input  logic       por_i,
  input  logic       wdt_evt_i,
  input  logic       usb_evt_i,
  input  logic       wake_i,
  input  logic       wr_hit_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] scr_o
);
  logic [7:0] scr_q;
  logic       any_evt;

  assign any_evt = wdt_evt_i || usb_evt_i;

  always_ff @(posedge clk) begin
    if (por_i) scr_q <= POWERON_VAL;
    else       scr_q <= scr_update(scr_q, wr_hit_i, wdata_i, wdt_evt_i, usb_evt_i, wake_i);
  end

  assign scr_o = scr_q;

  AST_POR_STICKY: assert property (@(posedge clk) disable iff (por_i)
    $fell(scr_q[B_POR]) |-> $past(wr_hit_i));                  // R4
  AST_RUN_ONLY_RESET: assert property (@(posedge clk) disable iff (por_i)
    $rose(scr_q[B_RUN]) |-> $past(any_evt));                   // R6
  AST_WDT_RECORD: assert property (@(posedge clk) disable iff (por_i)
    wdt_evt_i |=> scr_q[B_WDT]);                               // R3
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (por_i)
    scr_q[B_SUSP] && !wake_i && !wr_hit_i |=> scr_q[B_SUSP]);  // R9
endmodule

// File: rtl/rcc_fetch.sv
module rcc_fetch (
  input  logic clk,
  input  logic por_i,
  input  logic win_end_i,
  input  logic rst_i,
  input  logic susp_i,
  output logic fetch_o
);
  logic pend_q;

  assign fetch_o = pend_q && !susp_i && !rst_i;

  always_ff @(posedge clk) begin
    if (por_i)          pend_q <= 1'b0;
    else if (win_end_i) pend_q <= 1'b1;
    else if (fetch_o)   pend_q <= 1'b0;
  end

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (por_i)
    fetch_o |=> !fetch_o);                                     // R8
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rcc_pkg::*;
#(
  parameter int unsigned RST_CYC  = 4,
  parameter logic [7:0]  SCR_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       wdt_evt_i,
  input  logic       usb_rst_evt_i,
  input  logic       wake_i,
  input  logic [7:0] io_addr_i,
  input  logic       io_wr_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  output logic       sys_rst_o,
  output logic       cpu_run_o,
  output logic       vec_fetch_o,
  output logic       usb_tx_en_o,
  output logic       clk_stop_o
);
  logic       addr_hit, wr_hit, any_evt, win_end;
  logic [7:0] scr;

  assign addr_hit = (io_addr_i == SCR_ADDR);
  assign wr_hit   = io_wr_i && addr_hit;
  assign any_evt  = wdt_evt_i || usb_rst_evt_i;

  rcc_stretch #(.RST_CYC(RST_CYC)) u_stretch (
    .clk   (clk),
    .por_i (por_i),
    .evt_i (any_evt),
    .rst_o (sys_rst_o),
    .end_o (win_end)
  );

  rcc_state u_state (
    .clk       (clk),
    .por_i     (por_i),
    .wdt_evt_i (wdt_evt_i),
    .usb_evt_i (usb_rst_evt_i),
    .wake_i    (wake_i),
    .wr_hit_i  (wr_hit),
    .wdata_i   (io_wdata_i),
    .scr_o     (scr)
  );

  rcc_fetch u_fetch (
    .clk       (clk),
    .por_i     (por_i),
    .win_end_i (win_end),
    .rst_i     (sys_rst_o),
    .susp_i    (scr[B_SUSP]),
    .fetch_o   (vec_fetch_o)
  );

  assign io_rdata_o  = read_view(scr, addr_hit);
  assign clk_stop_o  = scr[B_SUSP];
  assign cpu_run_o   = scr[B_RUN] && !sys_rst_o && !scr[B_SUSP];
  assign usb_tx_en_o = !scr[B_WDT] && !sys_rst_o;
endmodule

// File: tb/rst_cause_ctl_tb_top.sv
module rst_cause_ctl_tb_top;
  logic       clk = 1'b0;
  logic       por = 1'b1, wdt = 1'b0, usb = 1'b0, wake = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'hFF, wd = 8'h00;
  logic [7:0] rdata;
  logic       srst, run, fetch, txen, cstop;
  int         checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rst_cause_ctl dut_i (
    .clk(clk), .por_i(por), .wdt_evt_i(wdt), .usb_rst_evt_i(usb), .wake_i(wake),
    .io_addr_i(addr), .io_wr_i(wr), .io_wdata_i(wd), .io_rdata_o(rdata),
    .sys_rst_o(srst), .cpu_run_o(run), .vec_fetch_o(fetch),
    .usb_tx_en_o(txen), .clk_stop_o(cstop)
  );

  // {write data, expected read-back}, starting from the power-on value 0x11
  localparam logic [15:0] VEC [8] = '{
    16'hFF_19, 16'h11_11, 16'h01_01, 16'h11_01,
    16'h86_00, 16'h01_00, 16'h08_08, 16'h00_00
  };

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_scr(input logic [7:0] d);
    wr = 1'b1; wd = d; tick(); wr = 1'b0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nrst, nfetch;
    tick(); tick(); tick();
    chk("R1 rst during por", {7'd0, srst}, 8'h01);
    por = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      tick();
      chk("R1 rst after por", {7'd0, srst}, 8'h01);
      chk("R10 run low in rst", {7'd0, run}, 8'h00);
    end
    chk("R1 por value", rdata, 8'h11);
    tick();
    chk("R1 rst released", {7'd0, srst}, 8'h00);
    chk("R8 fetch after por", {7'd0, fetch}, 8'h01);
    chk("R10 running", {6'd0, run, cstop}, 8'h02);
    tick();
    chk("R8 fetch one cycle", {7'd0, fetch}, 8'h00);

    // R4 R5 R6 R9: register write table
    foreach (VEC[k]) begin
      wr_scr(VEC[k][15:8]);
      chk($sformatf("R4/R5/R6/R9 vector %0d", k), rdata, VEC[k][7:0]);
    end
    chk("R6 run not restored by write", {7'd0, run}, 8'h00);

    // R3 R7 R2: watchdog reset
    wdt = 1'b1; tick(); wdt = 1'b0;
    chk("R3 wdt cause, R6 run set", rdata, 8'h41);
    for (int i = 1; i <= 4; i++) begin
      chk("R2 rst window", {6'd0, srst, txen}, 8'h02);
      tick();
    end
    chk("R2 rst end", {7'd0, srst}, 8'h00);
    chk("R8 fetch", {7'd0, fetch}, 8'h01);
    chk("R7 tx gated by wdt flag", {7'd0, txen}, 8'h00);
    chk("R10 run after reset", {7'd0, run}, 8'h01);
    wr_scr(8'h01);
    chk("R7 tx after clear", {7'd0, txen}, 8'h01);
    chk("R4 wdt cleared", rdata, 8'h01);

    // R2 R3: merged usb + wdt reset
    nrst = 0; nfetch = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (i > 0) begin nrst += int'(srst); nfetch += int'(fetch); end
      usb = (i == 0); wdt = (i == 2);
    end
    chk("R2 merged window length", 8'(nrst), 8'd6);
    chk("R8 single fetch for merged", 8'(nfetch), 8'd1);
    chk("R3 both causes", rdata, 8'h61);
    wr_scr(8'h01);

    // R9: suspend holds the fetch across a usb reset
    wr_scr(8'h09);
    chk("R9 clk stop", {6'd0, cstop, run}, 8'h02);
    usb = 1'b1; tick(); usb = 1'b0;
    nfetch = 0;
    for (int i = 0; i < 8; i++) begin nfetch += int'(fetch); tick(); end
    chk("R9 no fetch while suspended", 8'(nfetch), 8'd0);
    chk("R9 suspend survives usb reset", rdata, 8'h29);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R9 wake releases fetch", {6'd0, fetch, cstop}, 8'h02);
    tick();
    chk("R9 fetch done, R10 run", {6'd0, fetch, run}, 8'h01);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R9 wake ignored when awake", {rdata[6:0], fetch}, 8'h42);

    // R11: other addresses
    addr = 8'h21; wr_scr(8'h00);
    chk("R11 read elsewhere", rdata, 8'h00);
    addr = 8'hFF; #1;
    chk("R11 write elsewhere ignored", rdata, 8'h21);

    // R4 R1: power-on clears usb/wdt causes
    wdt = 1'b1; tick(); wdt = 1'b0;
    por = 1'b1; tick(); tick(); por = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    chk("R4 por resets causes", rdata, 8'h11);
    chk("R1 tx enabled after por", {6'd0, txen, srst}, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule